// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block holds a running time of day and calendar date as eight packed-BCD bytes. The bytes are hundredths, seconds, minutes, hours, weekday, day of month, month and two-digit year. Each pulse on a 100 Hz enable input advances the hundredths. Carries then ripple upward through the larger fields. The month length is taken from the current month and year, and February gains a 29th day in years divisible by four.

The hours byte can count in 24-hour form or in 12-hour form with a PM flag. A stop bit in the weekday byte freezes all counting. An external access unit writes all eight bytes at once through a 64-bit load port. The same unit reads them back through a 64-bit view port. The view port can be held still while the unit shifts a value out, so it never shows a half-updated time. Bits that carry no meaning are held at zero.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the view port reads 64'h0001_0101_0000_0000. This is the time 00:00:00.00 in 24-hour form, weekday 1, day 01, month 01, year 00, with the clock running. The byte map is: hundredths [7:0], seconds [15:8], minutes [23:16], hours [31:24], weekday [39:32], day of month [47:40], month [55:48], year [63:56].
- R2: Each cycle with tickEn high advances hundredths by one, wrapping from 99 to 00 with a carry into seconds. A cycle with tickEn low changes nothing.
- R3: Seconds and minutes each wrap from 59 to 00 and carry into the next field.
- R4: With hours bit 7 at 0 (24-hour form), hours count 00 to 23, with bits 5:4 as the tens digit. The wrap from 23 to 00 advances the date.
- R5: With hours bit 7 at 1 (12-hour form), bit 5 is PM and bits 4:0 hold 01 to 12. The sequence is 12, 01, …, 11, and the step from 11 to 12 toggles PM. The date advances only when 11 PM becomes 12 AM.
- R6: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11. It wraps after 31 in the other months, except 02. Month 02 wraps after 29 when the year is divisible by four, and after 28 otherwise.
- R7: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: Weekday (weekday bits 2:0) advances with each date change and wraps from 7 to 1.
- R9: While weekday bit 5 is 1, ticks change no register. The bit itself is kept through date changes.
- R10: The following bits always read 0, whatever was loaded:
  - seconds bit 7 and minutes bit 7;
  - hours bit 6;
  - weekday bits 7, 6, 4 and 3;
  - day-of-month bits 7:6;
  - month bits 7:5.
- R11: A cycle with loadEn high writes loadData, with the zero bits cleared, into all registers. A tick in the same cycle is discarded.
- R12: The view port follows the registers with one cycle of delay while holdView is low. It is frozen while holdView is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 100 Hz advance strobe, one cycle wide |
| loadEn | input | 1 | Parallel write strobe |
| loadData | input | 64 | Value for all eight registers |
| holdView | input | 1 | Freeze the view port |
| regsOut | output | 64 | Registered view of all eight registers |

## Verification
A wrong carry condition shows on the view port one cycle after the tick that should have crossed a boundary, as a field that fails to wrap or a neighbour that fails to step. Month-length and leap errors only appear at the end of a month, and 12-hour errors only at the 11 and 12 o'clock boundaries. For this reason, loads place the clock one tick before each of these points. Long random runs from random valid dates are compared with a decimal model, so that drift in any field is seen within a few hundred ticks.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int BUS_W    = BYTE_W * NUM_REGS;

  localparam int IDX_HUND  = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_WDAY  = 4;
  localparam int IDX_DATE  = 5;
  localparam int IDX_MONTH = 6;
  localparam int IDX_YEAR  = 7;

  localparam int HOUR_MODE_BIT = 7;
  localparam int HOUR_PM_BIT   = 5;
  localparam int WDAY_STOP_BIT = 5;

  localparam logic [BUS_W-1:0] FIELD_MASK = 64'hFF1F_3F27_BF7F_7FFF;
  localparam logic [BUS_W-1:0] RESET_VAL  = 64'h0001_0101_0000_0000;

  typedef struct packed {
    logic load;
    logic hund;
    logic sec;
    logic min;
    logic hour;
    logic date;
    logic month;
    logic year;
  } calStrobe_t;

  // Packed-BCD increment with wrap from maxV to minV.
  function automatic logic [7:0] bcdInc(input logic [7:0] val,
                                        input logic [7:0] minV,
                                        input logic [7:0] maxV);
    logic [7:0] res;
    if (val == maxV)            res = minV;
    else if (val[3:0] == 4'h9)  res = {val[7:4] + 4'd1, 4'h0};
    else                        res = val + 8'd1;
    return res;
  endfunction

  function automatic logic yearIsLeap(input logic [7:0] yearBcd);
    logic [6:0] yearBin;
    yearBin = ({3'b000, yearBcd[7:4]} * 7'd10) + {3'b000, yearBcd[3:0]};
    return (yearBin[1:0] == 2'b00);
  endfunction

  // Last valid day of month, packed BCD.
  function automatic logic [7:0] lastDay(input logic [7:0] monthBcd,
                                         input logic [7:0] yearBcd);
    logic [7:0] res;
    case (monthBcd)
      8'h02:                     res = yearIsLeap(yearBcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: res = 8'h30;
      default:                   res = 8'h31;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import bcd_calendar_pkg::*;
(
  input  logic             tickEn,
  input  logic             loadEn,
  input  logic [BUS_W-1:0] liveRegs,
  output calStrobe_t       strobes
);
  logic [7:0] hund, sec, min, hour, wday, date, month, year;
  logic       run, hundTop, secTop, minTop, hourTop, dateTop, monthTop;

  assign hund  = liveRegs[IDX_HUND*BYTE_W  +: BYTE_W];
  assign sec   = liveRegs[IDX_SEC*BYTE_W   +: BYTE_W];
  assign min   = liveRegs[IDX_MIN*BYTE_W   +: BYTE_W];
  assign hour  = liveRegs[IDX_HOUR*BYTE_W  +: BYTE_W];
  assign wday  = liveRegs[IDX_WDAY*BYTE_W  +: BYTE_W];
  assign date  = liveRegs[IDX_DATE*BYTE_W  +: BYTE_W];
  assign month = liveRegs[IDX_MONTH*BYTE_W +: BYTE_W];
  assign year  = liveRegs[IDX_YEAR*BYTE_W  +: BYTE_W];

  always_comb begin
    hundTop  = (hund == 8'h99);
    secTop   = (sec == 8'h59);
    minTop   = (min == 8'h59);
    if (hour[HOUR_MODE_BIT]) hourTop = (hour[4:0] == 5'h11) && hour[HOUR_PM_BIT];
    else                     hourTop = (hour[5:0] == 6'h23);
    dateTop  = (date == lastDay(month, year));
    monthTop = (month == 8'h12);
  end

  assign run = tickEn && !loadEn && !wday[WDAY_STOP_BIT];

  always_comb begin
    strobes.load  = loadEn;
    strobes.hund  = run;
    strobes.sec   = strobes.hund  && hundTop;
    strobes.min   = strobes.sec   && secTop;
    strobes.hour  = strobes.min   && minTop;
    strobes.date  = strobes.hour  && hourTop;
    strobes.month = strobes.date  && dateTop;
    strobes.year  = strobes.month && monthTop;
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import bcd_calendar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strobes,
  input  logic [BUS_W-1:0] loadData,
  input  logic             holdView,
  output logic [BUS_W-1:0] liveRegs,
  output logic [BUS_W-1:0] viewRegs
);
  logic [BUS_W-1:0] nextRegs;

  function automatic logic [7:0] hourNext(input logic [7:0] h);
    logic [7:0] res;
    logic [7:0] tmp;
    res = h;
    res[6] = 1'b0;
    if (!h[HOUR_MODE_BIT]) begin
      tmp = bcdInc({2'b00, h[5:0]}, 8'h00, 8'h23);
      res[5:0] = tmp[5:0];
    end else if (h[4:0] == 5'h12) begin
      res[4:0] = 5'h01;
    end else if (h[4:0] == 5'h11) begin
      res[4:0] = 5'h12;
      res[HOUR_PM_BIT] = ~h[HOUR_PM_BIT];
    end else begin
      tmp = bcdInc({3'b000, h[4:0]}, 8'h01, 8'h12);
      res[4:0] = tmp[4:0];
    end
    return res;
  endfunction

  always_comb begin
    nextRegs = liveRegs;
    if (strobes.load) begin
      nextRegs = loadData & FIELD_MASK;
    end else begin
      if (strobes.hund)
        nextRegs[IDX_HUND*BYTE_W +: BYTE_W] =
          bcdInc(liveRegs[IDX_HUND*BYTE_W +: BYTE_W], 8'h00, 8'h99);
      if (strobes.sec)
        nextRegs[IDX_SEC*BYTE_W +: BYTE_W] =
          bcdInc(liveRegs[IDX_SEC*BYTE_W +: BYTE_W], 8'h00, 8'h59);
      if (strobes.min)
        nextRegs[IDX_MIN*BYTE_W +: BYTE_W] =
          bcdInc(liveRegs[IDX_MIN*BYTE_W +: BYTE_W], 8'h00, 8'h59);
      if (strobes.hour)
        nextRegs[IDX_HOUR*BYTE_W +: BYTE_W] =
          hourNext(liveRegs[IDX_HOUR*BYTE_W +: BYTE_W]);
      if (strobes.date) begin
        nextRegs[IDX_WDAY*BYTE_W +: 3] =
          (liveRegs[IDX_WDAY*BYTE_W +: 3] == 3'd7) ? 3'd1
                                                   : liveRegs[IDX_WDAY*BYTE_W +: 3] + 3'd1;
        nextRegs[IDX_DATE*BYTE_W +: BYTE_W] = strobes.month ? 8'h01 :
          bcdInc(liveRegs[IDX_DATE*BYTE_W +: BYTE_W], 8'h01, 8'h31);
      end
      if (strobes.month)
        nextRegs[IDX_MONTH*BYTE_W +: BYTE_W] =
          bcdInc(liveRegs[IDX_MONTH*BYTE_W +: BYTE_W], 8'h01, 8'h12);
      if (strobes.year)
        nextRegs[IDX_YEAR*BYTE_W +: BYTE_W] =
          bcdInc(liveRegs[IDX_YEAR*BYTE_W +: BYTE_W], 8'h00, 8'h99);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveRegs <= RESET_VAL;
      viewRegs <= RESET_VAL;
    end else begin
      liveRegs <= nextRegs;
      if (!holdView) viewRegs <= liveRegs;
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             loadEn,
  input  logic [BUS_W-1:0] loadData,
  input  logic             holdView,
  output logic [BUS_W-1:0] regsOut
);
  calStrobe_t       strobes;
  logic [BUS_W-1:0] liveRegs;

  cal_ctrl i_ctrl (
    .tickEn  (tickEn),
    .loadEn  (loadEn),
    .liveRegs(liveRegs),
    .strobes (strobes)
  );

  cal_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadData(loadData),
    .holdView(holdView),
    .liveRegs(liveRegs),
    .viewRegs(regsOut)
  );
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_calendar_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             loadEn,
  input logic [BUS_W-1:0] loadData,
  input logic             holdView,
  input logic [BUS_W-1:0] liveRegs,
  input logic [BUS_W-1:0] regsOut
);
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !tickEn) |=> $stable(liveRegs));

  // R2
  hund_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !loadEn && !liveRegs[IDX_WDAY*BYTE_W + WDAY_STOP_BIT])
      |=> (liveRegs[7:0] != $past(liveRegs[7:0])));

  // R9
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && liveRegs[IDX_WDAY*BYTE_W + WDAY_STOP_BIT]) |=> $stable(liveRegs));

  // R10
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((regsOut & ~FIELD_MASK) == '0));

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (liveRegs == ($past(loadData) & FIELD_MASK)));

  // R12
  hold_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdView |=> $stable(regsOut));
endmodule

bind bcd_calendar bcd_calendar_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .loadEn  (loadEn),
  .loadData(loadData),
  .holdView(holdView),
  .liveRegs(liveRegs),
  .regsOut (regsOut)
);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  localparam logic [63:0] MASK = 64'hFF1F_3F27_BF7F_7FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        loadEn = 1'b0;
  logic [63:0] loadData = '0;
  logic        holdView = 1'b0;
  logic [63:0] regsOut;

  int          checks = 0;
  int          fails = 0;
  logic [63:0] model = 64'h0001_0101_0000_0000;

  always #2.5 clk = ~clk;

  bcd_calendar i_bcd_calendar (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .loadEn(loadEn),
    .loadData(loadData), .holdView(holdView), .regsOut(regsOut)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int monthDays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] y, mo, d, wd, h, mi, s, hu);
    return {y, mo, d, wd, h, mi, s, hu};
  endfunction

  // Decimal model of one 100 Hz step.
  function automatic logic [63:0] step(input logic [63:0] r);
    int hu, s, mi, h, wd, d, mo, y;
    logic twelve, pm, carry;
    if (r[37]) return r;
    hu = b2i(r[7:0]); s = b2i(r[15:8]); mi = b2i(r[23:16]);
    wd = int'(r[34:32]); d = b2i(r[47:40]); mo = b2i(r[55:48]); y = b2i(r[63:56]);
    twelve = r[31]; pm = r[29];
    h = twelve ? b2i({3'b000, r[28:24]}) : b2i({2'b00, r[29:24]});
    carry = 1'b0;
    hu++;
    if (hu == 100) begin
      hu = 0; s++;
      if (s == 60) begin
        s = 0; mi++;
        if (mi == 60) begin
          mi = 0;
          if (!twelve) begin
            h++;
            if (h == 24) begin h = 0; carry = 1'b1; end
          end else if (h == 11) begin
            h = 12; carry = pm; pm = !pm;
          end else if (h == 12) h = 1;
          else h++;
        end
      end
    end
    if (carry) begin
      wd = (wd == 7) ? 1 : wd + 1;
      d++;
      if (d > monthDays(mo, y)) begin
        d = 1; mo++;
        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
      end
    end
    r[7:0] = i2b(hu); r[15:8] = i2b(s); r[23:16] = i2b(mi);
    if (twelve) r[31:24] = {1'b1, 1'b0, pm, i2b(h)[4:0]};
    else        r[31:24] = {2'b00, i2b(h)[5:0]};
    r[34:32] = 3'(wd); r[47:40] = i2b(d); r[55:48] = i2b(mo); r[63:56] = i2b(y);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [63:0] v);
    @(negedge clk); loadEn = 1'b1; loadData = v;
    @(negedge clk); loadEn = 1'b0;
    model = v & MASK;
  endtask

  task automatic doTicks(input int n);
    @(negedge clk); tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    for (int i = 0; i < n; i++) model = step(model);
  endtask

  task automatic viewCheck(input string req, input logic [63:0] exp);
    @(negedge clk);
    check(req, regsOut, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset", regsOut, 64'h0001_0101_0000_0000);
    rstN = 1'b1;
    viewCheck("R1 after release", 64'h0001_0101_0000_0000);

    doTicks(1);
    viewCheck("R2 single tick", 64'h0001_0101_0000_0001);
    repeat (5) @(negedge clk);
    viewCheck("R2 idle no change", 64'h0001_0101_0000_0001);

    // R3 R4 R6 R8: leap February 28 -> 29, weekday 7 -> 1
    doLoad(mk(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R4 R6 R8 leap rollover", mk(8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));

    doLoad(mk(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R6 common-year February", mk(8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));

    doLoad(mk(8'h10, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R6 thirty-day month", mk(8'h10, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));

    doLoad(mk(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R7 year wrap", mk(8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00));

    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h14, 8'h58, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R3 minute carry", mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h14, 8'h59, 8'h00, 8'h00));

    // R5: 12-hour form
    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R5 11AM to 12PM", mk(8'h05, 8'h03, 8'h10, 8'h02, 8'hB2, 8'h00, 8'h00, 8'h00));
    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R5 11PM to 12AM", mk(8'h05, 8'h03, 8'h11, 8'h03, 8'h92, 8'h00, 8'h00, 8'h00));
    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h92, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R5 12 to 01", mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h81, 8'h00, 8'h00, 8'h00));

    // R9: stop bit
    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h22, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(20);
    viewCheck("R9 stopped", mk(8'h05, 8'h03, 8'h10, 8'h22, 8'h23, 8'h59, 8'h59, 8'h99));
    doLoad(mk(8'h05, 8'h03, 8'h10, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
    doTicks(1);
    viewCheck("R9 restarted", mk(8'h05, 8'h03, 8'h11, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));

    doLoad(64'hFFFF_FFFF_FFFF_FFFF);
    viewCheck("R10 zero bits", MASK);

    // R11: load and tick together
    @(negedge clk); loadEn = 1'b1; tickEn = 1'b1;
    loadData = mk(8'h42, 8'h07, 8'h04, 8'h01, 8'h12, 8'h34, 8'h56, 8'h78);
    @(negedge clk); loadEn = 1'b0; tickEn = 1'b0;
    model = loadData & MASK;
    viewCheck("R11 load wins", mk(8'h42, 8'h07, 8'h04, 8'h01, 8'h12, 8'h34, 8'h56, 8'h78));

    // R12: hold view
    held = regsOut;
    @(negedge clk); holdView = 1'b1;
    doTicks(50);
    check("R12 frozen view", regsOut, held);
    @(negedge clk); holdView = 1'b0;
    viewCheck("R12 released view", model);
    check("R2 fifty ticks", model, mk(8'h42, 8'h07, 8'h04, 8'h01, 8'h12, 8'h34, 8'h57, 8'h28));

    // Random runs against the decimal model (R2 R3 R4 R5 R6 R7 R8)
    for (int it = 0; it < 40; it++) begin
      int mo, y, d, h;
      logic twelve, pm;
      logic [7:0] hb;
      mo = 1 + int'($urandom % 12); y = int'($urandom % 100);
      d = ($urandom % 2) ? monthDays(mo, y) : 1 + int'($urandom % monthDays(mo, y));
      twelve = 1'($urandom % 2); pm = 1'($urandom % 2);
      if (twelve) begin
        h = ($urandom % 2) ? 11 : 1 + int'($urandom % 12);
        hb = {1'b1, 1'b0, pm, i2b(h)[4:0]};
      end else begin
        h = ($urandom % 2) ? 23 : int'($urandom % 24);
        hb = {2'b00, i2b(h)[5:0]};
      end
      doLoad(mk(i2b(y), i2b(mo), i2b(d), 8'(1 + $urandom % 7), hb,
                8'h59, i2b(55 + int'($urandom % 5)), i2b(int'($urandom % 100))));
      doTicks(1 + int'($urandom % 400));
      viewCheck("R2-model random run", model);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule